// File: doc/BRIEF.md
# Interrupt Cause Register with Write-One-to-Clear Flags

This block holds the sticky interrupt causes of a network controller's host interface. Three hardware events latch into flags: a received frame has completed, a transmit frame has been handed to the transmit FIFO, and the initialization block has been loaded. A pulse on the matching event input sets the flag, and the flag stays set until the host acknowledges it. The host clears a flag by writing a one to its bit position. The host can therefore read the register and write the same word back to acknowledge every pending cause at once.

The register is reached indirectly. An external pointer register decodes to `reg_sel`, and data-port reads and writes then reach this word. Each flag has its own mask bit, and the flags are combined with several other enabled sources into a summary bit. The summary, gated by a global enable, drives a registered active-high interrupt output. Some critical sources, such as system error or sleep, raise the output even when the global enable is off. The receive flag can also fire on the first descriptor of a frame when a look-ahead option is on. Software reset and setting the stop control bit wipe all three flags.

Top module: `irq_cause_reg`

## Requirements
- R1: After hardware reset (`rst_n` low), all three flags are 0, `irq_o` is 0 and the register reads as 0.
- R2: Bit 10 (receive flag) sets on the cycle after an `ev_rx_last` pulse. An `ev_rx_first` pulse also sets it, but only while `lookahead_en` is 1; otherwise `ev_rx_first` has no effect.
- R3: Bit 9 (transmit flag) sets after an `ev_tx_done` pulse, and bit 8 (init-done flag) sets after an `ev_init_done` pulse.
- R4: A write with `reg_sel` and `wr_en` high clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A write with `reg_sel` low changes nothing.
- R5: If an event and a write-one-to-clear hit the same flag in one cycle, the flag ends up set.
- R6: A `soft_rst` or `stop_set` pulse clears all three flags on the next edge, even if an event arrives in the same cycle.
- R7: The following bits of `rd_data` always read 0, whatever was written: bits 31..16, bits 15..11 (which accept writes) and bits 6..0. `rd_data` is all zero while `reg_sel` is low.
- R8: Bit 7 of `rd_data` is the summary. It is 1 when any of the following holds:
  - a flag is set whose mask bit is 0 (`irq_mask[2]`=receive, `[1]`=transmit, `[0]`=init-done, 1 masks);
  - any `ext_cause[i]` is 1 with `ext_en[i]` 1;
  - any `crit_cause[j]` is 1 with `crit_en[j]` 1.
- R9: `irq_o` is registered. One cycle after given inputs and state, it equals (summary AND `glob_en`) OR any enabled critical cause.
- R10: With no event, no write and no wipe, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse, clears flags |
| stop_set | input | 1 | Pulse when the stop control bit is set, clears flags |
| reg_sel | input | 1 | Pointer decode selects this register |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 32 | Data-port write word |
| rd_data | output | 32 | Data-port read word |
| ev_rx_last | input | 1 | Last receive descriptor released |
| ev_rx_first | input | 1 | First receive descriptor released |
| lookahead_en | input | 1 | Allows the first-descriptor event to set the receive flag |
| ev_tx_done | input | 1 | Last transmit descriptor released |
| ev_init_done | input | 1 | Initialization block read |
| irq_mask | input | 3 | Masks for receive, transmit, init-done (1 masks) |
| ext_cause | input | N_EXT | Other interrupt sources, level |
| ext_en | input | N_EXT | Enables for `ext_cause` |
| crit_cause | input | N_CRIT | Critical sources that ignore the global enable |
| crit_en | input | N_CRIT | Enables for `crit_cause` |
| glob_en | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The bench builds the block with `N_EXT` = 3 and `N_CRIT` = 2. These widths are small enough that random enables often leave exactly one cause active, so the summary and the enable bypass for critical sources are each driven on their own. Wipe pulses and lookahead on/off occur across the random run, and directed cycles cover the collision orderings between events, clears and wipes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned N_FLAG  = 3;
    localparam int unsigned RX_POS  = 10;
    localparam int unsigned TX_POS  = 9;
    localparam int unsigned ID_POS  = 8;
    localparam int unsigned SUM_POS = 7;
    // flag vector order: [2]=receive, [1]=transmit, [0]=init-done
    localparam int unsigned F_RX = 2;
    localparam int unsigned F_TX = 1;
    localparam int unsigned F_ID = 0;

    typedef struct packed {
        logic [N_FLAG-1:0] flag;
    } bank_st_t;

    typedef struct packed {
        logic irq;
    } sum_st_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_i,
    input  logic [N_FLAG-1:0] clr_i,
    input  logic              wipe_i,
    output logic [N_FLAG-1:0] flag_o
);
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_FLAG; i++) begin
            // priority: wipe, then event, then host clear
            if (wipe_i)        st_d.flag[i] = 1'b0;
            else if (set_i[i]) st_d.flag[i] = 1'b1;
            else if (clr_i[i]) st_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_pkg::*;
#(
    parameter int unsigned N_EXT  = 4,
    parameter int unsigned N_CRIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] flag_i,
    input  logic [N_FLAG-1:0] mask_i,
    input  logic [N_EXT-1:0]  ext_cause_i,
    input  logic [N_EXT-1:0]  ext_en_i,
    input  logic [N_CRIT-1:0] crit_cause_i,
    input  logic [N_CRIT-1:0] crit_en_i,
    input  logic              glob_en_i,
    output logic              summary_o,
    output logic              irq_o
);
    sum_st_t st_d, st_q;
    logic    crit_any;
    logic    flag_any;
    logic    ext_any;

    always_comb begin
        flag_any  = |(flag_i & ~mask_i);
        ext_any   = |(ext_cause_i & ext_en_i);
        crit_any  = |(crit_cause_i & crit_en_i);
        summary_o = flag_any | ext_any | crit_any;
        st_d.irq  = (summary_o & glob_en_i) | crit_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_pkg::*;
#(
    parameter int unsigned N_EXT  = 4,
    parameter int unsigned N_CRIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stop_set,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_rx_last,
    input  logic              ev_rx_first,
    input  logic              lookahead_en,
    input  logic              ev_tx_done,
    input  logic              ev_init_done,
    input  logic [N_FLAG-1:0] irq_mask,
    input  logic [N_EXT-1:0]  ext_cause,
    input  logic [N_EXT-1:0]  ext_en,
    input  logic [N_CRIT-1:0] crit_cause,
    input  logic [N_CRIT-1:0] crit_en,
    input  logic              glob_en,
    output logic              irq_o
);
    logic [N_FLAG-1:0] set_v;
    logic [N_FLAG-1:0] clr_v;
    logic [N_FLAG-1:0] flags_q;
    logic              wipe;
    logic              host_wr;
    logic              summary;

    always_comb begin
        host_wr     = reg_sel & wr_en;
        wipe        = soft_rst | stop_set;
        set_v[F_RX] = ev_rx_last | (ev_rx_first & lookahead_en);
        set_v[F_TX] = ev_tx_done;
        set_v[F_ID] = ev_init_done;
        clr_v[F_RX] = host_wr & wr_data[RX_POS];
        clr_v[F_TX] = host_wr & wr_data[TX_POS];
        clr_v[F_ID] = host_wr & wr_data[ID_POS];
    end

    irq_flag_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .wipe_i (wipe),
        .flag_o (flags_q)
    );

    irq_summary #(.N_EXT(N_EXT), .N_CRIT(N_CRIT)) u_sum (
        .clk          (clk),
        .rst_n        (rst_n),
        .flag_i       (flags_q),
        .mask_i       (irq_mask),
        .ext_cause_i  (ext_cause),
        .ext_en_i     (ext_en),
        .crit_cause_i (crit_cause),
        .crit_en_i    (crit_en),
        .glob_en_i    (glob_en),
        .summary_o    (summary),
        .irq_o        (irq_o)
    );

    always_comb begin
        rd_data = '0;
        if (reg_sel) begin
            rd_data[RX_POS]  = flags_q[F_RX];
            rd_data[TX_POS]  = flags_q[F_TX];
            rd_data[ID_POS]  = flags_q[F_ID];
            rd_data[SUM_POS] = summary;
        end
    end
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
    import irq_pkg::*;
#(
    parameter int unsigned N_CRIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              stop_set,
    input logic              reg_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              ev_rx_last,
    input logic              ev_rx_first,
    input logic              lookahead_en,
    input logic              ev_tx_done,
    input logic              ev_init_done,
    input logic [N_CRIT-1:0] crit_cause,
    input logic [N_CRIT-1:0] crit_en,
    input logic              irq_o,
    input logic [N_FLAG-1:0] flags
);
    logic any_ev;
    logic rx_ev;
    assign rx_ev  = ev_rx_last | (ev_rx_first & lookahead_en);
    assign any_ev = rx_ev | ev_tx_done | ev_init_done;

    p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ev && !soft_rst && !stop_set) |=> flags[F_RX]);

    p_tx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_done && !soft_rst && !stop_set) |=> flags[F_TX]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && wr_en && wr_data[RX_POS] && !rx_ev) |=> !flags[F_RX]);

    p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || stop_set) |=> (flags == '0));

    p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:11] == '0) && (rd_data[6:0] == '0));

    p_crit_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(crit_cause & crit_en)) |=> irq_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !soft_rst && !stop_set && !(reg_sel && wr_en)) |=> $stable(flags));
endmodule

bind irq_cause_reg irq_cause_chk #(.N_CRIT(N_CRIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .stop_set     (stop_set),
    .reg_sel      (reg_sel),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .ev_rx_last   (ev_rx_last),
    .ev_rx_first  (ev_rx_first),
    .lookahead_en (lookahead_en),
    .ev_tx_done   (ev_tx_done),
    .ev_init_done (ev_init_done),
    .crit_cause   (crit_cause),
    .crit_en      (crit_en),
    .irq_o        (irq_o),
    .flags        (flags_q)
);

// File: tb/irq_cause_reg_test.sv
module irq_cause_reg_test;
    localparam int NX = 3;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, stop_set = 0, reg_sel = 0, wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic ev_rx_last = 0, ev_rx_first = 0, lookahead_en = 0;
    logic ev_tx_done = 0, ev_init_done = 0;
    logic [2:0] irq_mask = '0;
    logic [NX-1:0] ext_cause = '0, ext_en = '0;
    logic [NC-1:0] crit_cause = '0, crit_en = '0;
    logic glob_en = 0;
    logic irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] m_flag = '0;   // [2]=rx [1]=tx [0]=init
    logic       m_irq  = 1'b0;

    always #4 clk = ~clk;

    irq_cause_reg #(.N_EXT(NX), .N_CRIT(NC)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_set(stop_set),
        .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_rx_last(ev_rx_last), .ev_rx_first(ev_rx_first),
        .lookahead_en(lookahead_en), .ev_tx_done(ev_tx_done),
        .ev_init_done(ev_init_done), .irq_mask(irq_mask),
        .ext_cause(ext_cause), .ext_en(ext_en), .crit_cause(crit_cause),
        .crit_en(crit_en), .glob_en(glob_en), .irq_o(irq_o)
    );

    function automatic logic f_sum(logic [2:0] fl);
        return (|(fl & ~irq_mask)) | (|(ext_cause & ext_en)) | (|(crit_cause & crit_en));
    endfunction

    function automatic logic [31:0] f_rd(logic [2:0] fl);
        logic [31:0] w = '0;
        if (reg_sel) begin
            w[10] = fl[2]; w[9] = fl[1]; w[8] = fl[0]; w[7] = f_sum(fl);
        end
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply current inputs for one edge, update model, compare afterwards
    task automatic step(string req);
        logic [2:0] setv, clrv;
        m_irq = (f_sum(m_flag) & glob_en) | (|(crit_cause & crit_en));
        setv = {ev_rx_last | (ev_rx_first & lookahead_en), ev_tx_done, ev_init_done};
        clrv = (reg_sel && wr_en) ? {wr_data[10], wr_data[9], wr_data[8]} : 3'b000;
        if (soft_rst || stop_set) m_flag = '0;
        else m_flag = (m_flag & ~clrv) | setv;
        @(posedge clk);
        #1;
        check({req, " rd"}, rd_data, f_rd(m_flag));
        check({req, " irq R9"}, {31'b0, irq_o}, {31'b0, m_irq});
        @(negedge clk);
    endtask

    task automatic idle();
        soft_rst = 0; stop_set = 0; wr_en = 0; wr_data = '0;
        ev_rx_last = 0; ev_rx_first = 0; ev_tx_done = 0; ev_init_done = 0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        reg_sel = 1;
        #3;
        check("R1 reset rd", rd_data, 32'h0);
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        glob_en = 1;

        // R2: first-descriptor event ignored without lookahead
        idle(); ev_rx_first = 1; lookahead_en = 0; step("R2 first no-la");
        idle(); ev_rx_first = 1; lookahead_en = 1; step("R2 first la");
        idle(); reg_sel = 1; wr_en = 1; wr_data = 32'h0000_0400; step("R4 clear rx");
        idle(); ev_rx_last = 1; step("R2 last");
        // R3
        idle(); ev_tx_done = 1; ev_init_done = 1; step("R3 tx init");
        // R4: write zeros leaves flags, unselected write does nothing
        idle(); wr_en = 1; wr_data = 32'h0; step("R4 write zero");
        idle(); reg_sel = 0; wr_en = 1; wr_data = 32'hFFFF_FFFF; step("R4 unselected");
        reg_sel = 1;
        // R7: legacy and reserved bits written, read back zero
        idle(); wr_en = 1; wr_data = 32'hFFFF_F800; step("R7 legacy write");
        // R5: event beats clear
        idle(); ev_tx_done = 1; wr_en = 1; wr_data = 32'h0000_0700; step("R5 collide");
        // R6: wipe beats event
        idle(); ev_rx_last = 1; ev_init_done = 1; step("R10 setup");
        idle(); stop_set = 1; ev_tx_done = 1; step("R6 stop");
        idle(); ev_rx_last = 1; step("R10 setup2");
        idle(); soft_rst = 1; ev_rx_last = 1; step("R6 soft");
        // R9: critical cause with global enable off
        idle(); glob_en = 0; crit_cause = 2'b10; crit_en = 2'b10; step("R9 crit");
        idle(); step("R9 crit hold");
        crit_cause = '0;
        idle(); ev_tx_done = 1; step("R8 tx set");
        idle(); irq_mask = 3'b010; glob_en = 1; step("R8 masked");
        idle(); irq_mask = 3'b000; step("R8 unmasked");

        for (int k = 0; k < 3000; k++) begin
            idle();
            ev_rx_last   = ($urandom % 8) == 0;
            ev_rx_first  = ($urandom % 8) == 0;
            ev_tx_done   = ($urandom % 8) == 0;
            ev_init_done = ($urandom % 10) == 0;
            lookahead_en = $urandom % 2;
            reg_sel      = ($urandom % 4) != 0;
            wr_en        = ($urandom % 4) == 0;
            wr_data      = $urandom;
            soft_rst     = ($urandom % 40) == 0;
            stop_set     = ($urandom % 40) == 0;
            if (($urandom % 16) == 0) irq_mask = $urandom;
            ext_cause    = (($urandom % 4) == 0) ? NX'($urandom) : '0;
            ext_en       = NX'($urandom);
            crit_cause   = (($urandom % 6) == 0) ? NC'($urandom) : '0;
            crit_en      = NC'($urandom);
            glob_en      = ($urandom % 4) != 0;
            step("R2 R3 R4 R5 R6 R7 R8 R10 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule